// File: doc/BRIEF.md
# Floating-Point Mantissa Normalizer

This block takes an unnormalized floating-point result and brings it into normal form. The input is a sign bit, a signed true exponent and a mantissa. The mantissa carries one extra integer bit above its binary point, so a carry out of an addition can be passed in. The output is a 32-bit word with a sign bit, a 7-bit exponent stored in excess-64 code and a 24-bit fraction. Three flags come with the word: overflow, underflow and zero.

The block works as an iterative loop. It shifts by one position per clock, or by one nibble per clock when the implied base is 16. Each shift moves the exponent one step in the opposite direction. A new job is accepted with a start pulse while the block is idle. Completion is marked by a one-cycle done pulse, and the word and flags then stay put until the next job finishes. The base is chosen at build time. Rounding is not part of this block: any bits shifted out on the right are dropped.

Top module: `fpn_norm`

## Requirements
- R1: The output word holds the sign in bit 31, the stored exponent in bits 30:24 and the fraction in bits 23:0. The stored exponent equals the true exponent plus 64, so a true -64 is stored as 0, a true 0 as 64 and a true 63 as 127.
- R2: With base 2, a mantissa whose top fraction bit (bit 23) is 0 is shifted left by one bit per clock, and the exponent drops by one per shift. This continues until bit 23 is 1.
- R3: When the integer bit (`mant_i[24]`) is set, the mantissa is shifted right once: by 1 bit in base 2, or by 4 bits in base 16. The exponent rises by one.
- R4: With base 16, each shift moves the mantissa 4 bits and changes the exponent by one. The result counts as normalized once any of the fraction bits 23:20 is 1.
- R5: If the final true exponent is above 63, `ovf_o` is set. The word then saturates to the same sign, stored exponent 127 and fraction all ones.
- R6: If the final true exponent is below -64, `unf_o` is set and the word becomes all zero.
- R7: An all-zero mantissa skips the shifting. It yields an all-zero word with `zero_o` set, and `done_o` follows one clock after the start is accepted.
- R8: `done_o` is a single-cycle pulse. It is raised N+1 clocks after the edge that accepts `start_i`, where N is the number of shifts. `busy_o` is high from acceptance until completion, and it is low while `done_o` is high.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. The running job's result is unchanged, and no new job starts afterwards.
- R10: At most one of `ovf_o`, `unf_o` and `zero_o` is set. The word and the flags hold their values until the next completion. After reset they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a job when the block is idle |
| sign_i | input | 1 | Sign of the operand |
| exp_i | input | 9 | Signed true exponent of the operand |
| mant_i | input | 25 | Mantissa: bit 24 is the integer/carry bit, bits 23:0 are the fraction |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | 32 | Packed normalized result |
| ovf_o | output | 1 | Exponent overflow, word saturated |
| unf_o | output | 1 | Exponent underflow, word flushed to zero |
| zero_o | output | 1 | Mantissa was zero |

## Verification
Every result becomes visible N+1 clock edges after the edge that accepts the start. N is known in advance from the operand: it is the number of left shifts needed to reach the leading one, or a single right shift when there is a carry. So each directed case states its expected N. The bench counts falling edges from the start and requires `done_o` to appear at exactly N+2 of them. It samples the word and flags in that same half-cycle, then confirms one falling edge later that `done_o` has dropped. For the ignored-start case, the bench compares the original job's latency and word, and it checks that `busy_o` is low one falling edge after completion.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} fpn_state_e;
endpackage

// File: rtl/fpn_step.sv
// One shift/adjust step plus the normal-form test.
module fpn_step #(
  parameter int unsigned MANT_W = 24,
  parameter int unsigned XW     = 11,
  parameter bit          BASE16 = 1'b0
) (
  input  logic [MANT_W:0]        mant_i,
  input  logic signed [XW-1:0]   exp_i,
  output logic [MANT_W:0]        mant_o,
  output logic signed [XW-1:0]   exp_o,
  output logic                   norm_o,
  output logic                   zero_o
);
  localparam int unsigned STEP = BASE16 ? 4 : 1;
  localparam logic signed [XW-1:0] ONE = XW'(1);

  logic carry, top_hit;
  assign carry = mant_i[MANT_W];

  generate
    if (BASE16) begin : g_b16
      assign top_hit = |mant_i[MANT_W-1 -: 4];
    end else begin : g_b2
      assign top_hit = mant_i[MANT_W-1];
    end
  endgenerate

  assign norm_o = !carry && top_hit;
  assign zero_o = (mant_i == '0);

  always_comb begin
    if (carry) begin
      mant_o = mant_i >> STEP;
      exp_o  = exp_i + ONE;
    end else begin
      mant_o = mant_i << STEP;
      exp_o  = exp_i - ONE;
    end
  end
endmodule

// File: rtl/fpn_pack.sv
// Range check, saturation/flush and excess-code packing.
module fpn_pack #(
  parameter int unsigned MANT_W = 24,
  parameter int unsigned EXP_W  = 7,
  parameter int unsigned XW     = 11,
  localparam int unsigned WORD_W = 1 + EXP_W + MANT_W
) (
  input  logic                 sign_i,
  input  logic signed [XW-1:0] exp_i,
  input  logic [MANT_W-1:0]    mant_i,
  input  logic                 zero_i,
  output logic [WORD_W-1:0]    word_o,
  output logic                 ovf_o,
  output logic                 unf_o,
  output logic                 zero_o
);
  localparam logic signed [XW-1:0] EMAX = XW'((2 ** (EXP_W - 1)) - 1);
  localparam logic signed [XW-1:0] EMIN = -XW'(2 ** (EXP_W - 1));

  logic [EXP_W-1:0] field;
  // excess-2^(n-1) == two's complement with the MSB inverted
  assign field = {~exp_i[EXP_W-1], exp_i[EXP_W-2:0]};

  assign zero_o = zero_i;
  assign ovf_o  = !zero_i && (exp_i > EMAX);
  assign unf_o  = !zero_i && (exp_i < EMIN);

  always_comb begin
    if (zero_i || unf_o) word_o = '0;
    else if (ovf_o)      word_o = {sign_i, {(WORD_W-1){1'b1}}};
    else                 word_o = {sign_i, field, mant_i};
  end
endmodule

// File: rtl/fpn_norm.sv
module fpn_norm #(
  parameter int unsigned MANT_W = 24,
  parameter int unsigned EXP_W  = 7,
  parameter bit          BASE16 = 1'b0,
  localparam int unsigned WORD_W = 1 + EXP_W + MANT_W,
  localparam int unsigned IXW    = EXP_W + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  sign_i,
  input  logic signed [IXW-1:0] exp_i,
  input  logic [MANT_W:0]       mant_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [WORD_W-1:0]     word_o,
  output logic                  ovf_o,
  output logic                  unf_o,
  output logic                  zero_o
);
  import fpn_pkg::*;

  localparam int unsigned XW = EXP_W + 4;

  fpn_state_e             state_q;
  logic                   sign_q, done_q, ovf_q, unf_q, zero_q;
  logic signed [XW-1:0]   exp_q;
  logic [MANT_W:0]        mant_q;
  logic [WORD_W-1:0]      word_q;

  logic [MANT_W:0]        st_mant;
  logic signed [XW-1:0]   st_exp;
  logic                   st_norm, st_zero;
  logic [WORD_W-1:0]      pk_word;
  logic                   pk_ovf, pk_unf, pk_zero;

  fpn_step #(.MANT_W(MANT_W), .XW(XW), .BASE16(BASE16)) u_step (
    .mant_i (mant_q),
    .exp_i  (exp_q),
    .mant_o (st_mant),
    .exp_o  (st_exp),
    .norm_o (st_norm),
    .zero_o (st_zero)
  );

  fpn_pack #(.MANT_W(MANT_W), .EXP_W(EXP_W), .XW(XW)) u_pack (
    .sign_i (sign_q),
    .exp_i  (exp_q),
    .mant_i (mant_q[MANT_W-1:0]),
    .zero_i (st_zero),
    .word_o (pk_word),
    .ovf_o  (pk_ovf),
    .unf_o  (pk_unf),
    .zero_o (pk_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sign_q  <= 1'b0;
      exp_q   <= '0;
      mant_q  <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sign_q  <= sign_i;
          exp_q   <= XW'(exp_i);
          mant_q  <= mant_i;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (st_zero || st_norm) begin
            word_q  <= pk_word;
            ovf_q   <= pk_ovf;
            unf_q   <= pk_unf;
            zero_q  <= pk_zero;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            mant_q <= st_mant;
            exp_q  <= st_exp;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
  assign word_o = word_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;
  assign zero_o = zero_q;
endmodule

// File: rtl/fpn_norm_chk.sv
module fpn_norm_chk #(
  parameter int unsigned MANT_W = 24,
  parameter int unsigned EXP_W  = 7,
  parameter bit          BASE16 = 1'b0,
  localparam int unsigned WORD_W = 1 + EXP_W + MANT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] word_o,
  input logic              ovf_o,
  input logic              unf_o,
  input logic              zero_o
);
  logic top_hit;
  assign top_hit = BASE16 ? |word_o[MANT_W-1 -: 4] : word_o[MANT_W-1];

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  busy_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R10
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o, zero_o}));
  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(word_o));
  // R5
  ovf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (word_o[WORD_W-2:0] == {(WORD_W-1){1'b1}}));
  // R6
  unf_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (word_o == '0));
  // R7
  zero_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (word_o == '0));
  // R2
  norm_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ovf_o && !unf_o && !zero_o) |-> top_hit);
endmodule

bind fpn_norm fpn_norm_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W), .BASE16(BASE16)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .word_o  (word_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o),
  .zero_o  (zero_o)
);

// File: tb/tb_fpn_norm.sv
`timescale 1ns/1ps
module tb_fpn_norm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0;
  logic sign_in = 1'b0;
  logic signed [8:0] exp_in = '0;
  logic [24:0] mant_in = '0;
  logic busy_a, done_a, ovf_a, unf_a, zero_a;
  logic busy_b, done_b, ovf_b, unf_b, zero_b;
  logic [31:0] word_a, word_b;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  fpn_norm #(.BASE16(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .sign_i(sign_in),
    .exp_i(exp_in), .mant_i(mant_in), .busy_o(busy_a), .done_o(done_a),
    .word_o(word_a), .ovf_o(ovf_a), .unf_o(unf_a), .zero_o(zero_a));

  fpn_norm #(.BASE16(1'b1)) dut_b16 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .sign_i(sign_in),
    .exp_i(exp_in), .mant_i(mant_in), .busy_o(busy_b), .done_o(done_b),
    .word_o(word_b), .ovf_o(ovf_b), .unf_o(unf_b), .zero_o(zero_b));

  task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [35:0] outs(input bit b16);
    return b16 ? {busy_b, done_b, ovf_b, unf_b, zero_b, word_b[30:0]}
               : {busy_a, done_a, ovf_a, unf_a, zero_a, word_a[30:0]};
  endfunction

  function automatic logic [31:0] wsel(input bit b16);
    return b16 ? word_b : word_a;
  endfunction

  // Launch one job; done expected at falling edge n+2 after the launching one.
  task automatic run_case(input string req, input bit b16, input bit s, input int e,
                          input logic [24:0] m, input int n, input logic [31:0] ew,
                          input bit eo, input bit eu, input bit ez);
    int j;
    logic [35:0] o;
    @(negedge clk);
    sign_in = s; exp_in = 9'(e); mant_in = m;
    if (b16) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    j = 1;
    o = outs(b16);
    while (!o[34] && j < 100) begin
      check(o[35], {req, " busy while running (R8)"}, o[35], 1);
      @(negedge clk); j++; o = outs(b16);
    end
    check(j == n + 2, {req, " latency (R8)"}, j, n + 2);
    check(wsel(b16) == ew, {req, " word"}, wsel(b16), ew);
    check(o[33:31] == {eo, eu, ez}, {req, " flags ovf/unf/zero"}, o[33:31], {eo, eu, ez});
    @(negedge clk);
    o = outs(b16);
    check(!o[34], {req, " done one cycle (R8)"}, o[34], 0);
    check(wsel(b16) == ew, {req, " word held (R10)"}, wsel(b16), ew);
  endtask

  task automatic t_reset();
    check({busy_a, done_a, ovf_a, unf_a, zero_a} == 5'b0, "R10 reset flags", {busy_a, done_a, ovf_a, unf_a, zero_a}, 0);
    check(word_a == 32'h0, "R10 reset word", word_a, 0);
  endtask

  task automatic t_busy_ignore();
    int j;
    @(negedge clk);
    sign_in = 1'b1; exp_in = 9'sd10; mant_in = 25'h000001;
    start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    j = 1;
    repeat (4) begin @(negedge clk); j++; end
    sign_in = 1'b0; exp_in = 9'sd0; mant_in = 25'h0800000;
    start_a = 1'b1;
    @(negedge clk); j++;
    start_a = 1'b0;
    while (!done_a && j < 100) begin @(negedge clk); j++; end
    check(j == 25, "R9 latency unchanged", j, 25);
    check(word_a == 32'hB380_0000, "R9 result of first job", word_a, 32'hB380_0000);
    @(negedge clk);
    check(!busy_a, "R9 no job started by ignored start", busy_a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R1 packing, already normal
    run_case("R1 norm", 0, 0, 0,   25'h0800000, 0,  32'h4080_0000, 0, 0, 0);
    // R2 23 left shifts
    run_case("R2 deep", 0, 1, 10,  25'h0000001, 23, 32'hB380_0000, 0, 0, 0);
    // R3 carry
    run_case("R3 carry", 0, 0, 5,  25'h1400000, 1,  32'h46A0_0000, 0, 0, 0);
    // R5 carry pushes exponent to 64
    run_case("R5 ovf", 0, 1, 63,   25'h1000000, 1,  32'hFFFF_FFFF, 1, 0, 0);
    // R6 ends at -75
    run_case("R6 unf", 0, 1, -60,  25'h0000100, 15, 32'h0000_0000, 0, 1, 0);
    // R7 zero mantissa
    run_case("R7 zero", 0, 1, 20,  25'h0000000, 0,  32'h0000_0000, 0, 0, 1);
    // R1 lower bound -64 exactly
    run_case("R1 emin", 0, 0, -63, 25'h0400000, 1,  32'h0080_0000, 0, 0, 0);
    // R1 upper bound 63 exactly
    run_case("R1 emax", 0, 1, 63,  25'h0800000, 0,  32'hFF80_0000, 0, 0, 0);
    // R4 base 16 nibble shifts
    run_case("R4 b16", 1, 0, 0,    25'h0000010, 4,  32'h3C10_0000, 0, 0, 0);
    run_case("R3 b16 carry", 1, 0, 2, 25'h1000000, 1, 32'h4310_0000, 0, 0, 0);
    run_case("R4 b16 norm", 1, 1, -1, 25'h0300000, 0, 32'hBF30_0000, 0, 0, 0);
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule